// File: doc/BRIEF.md
# Cascadable Two-Channel Command Parity Checker

This block checks the parity of a registered command bus. The bus is split into two channel groups. Each group has its own parity bit, which arrives some cycles after the data it covers. For each channel the block reduces the group's data bits to one parity bit, lines that bit up with the late parity input, and forms a combined parity result. The result is presented as a partial-parity output. A non-zero result also drives an active-low error flag, which stays low for two cycles.

A static mode input chooses the role of the block. In front mode (0), which also serves a block used on its own, the parity input covers the data presented one cycle earlier. In back mode (1), it covers the data presented two cycles earlier. This second setting lets two blocks be chained. The front block's partial-parity outputs drive the back block's parity inputs, and the back block's error flags then report the parity over both halves of a wider bus. The front block's error flags go unused in that arrangement. When both chip-select style gating inputs are high, the outputs and the error hold state freeze.

Top module: `par_cascade_chk`

## Requirements
- R1: Channel 0 covers data bits 10..0 and channel 1 covers data bits 22..12. Bits 11 and 23 are in neither group and have no effect on any output. Each channel uses only its own group and its own parity input bit (par_i[0] for channel 0, par_i[1] for channel 1).
- R2: In front mode (mode_i = 0), suppose a group is presented in cycle n and its parity bit in cycle n+1. Then, during cycle n+2, ppo_o of that channel equals the XOR of the group's bits and the parity bit: 0 for an even count with parity 0, 1 for an odd count with parity 0.
- R3: In back mode (mode_i = 1), the parity bit for data presented in cycle n is taken in cycle n+2, and the result shows during cycle n+3. mode_i changes only while reset is held.
- R4: When a channel's combined parity is 1 at an enabled edge, its err_n_o goes low in the next cycle. When the result is 0 and no hold is running, err_n_o goes high.
- R5: After the last edge that saw a combined parity of 1, err_n_o stays low for exactly two enabled cycles. A new error during the hold restarts the two-cycle count.
- R6: At a clock edge where cs_a_n_i and cs_b_n_i are both high, ppo_o, err_n_o and the hold count do not change. If either select is low, the edge is enabled.
- R7: While rst_n_i is low, ppo_o is 0 and err_n_o is all ones, taking effect without waiting for a clock. After rst_n_i rises, the first two clock edges leave the outputs at these values, and the third edge is the first to update them.
- R8: Two blocks can be chained: a front block (mode 0) whose ppo_o drives the par_i of a back block (mode 1), each block taking its own data half. Then the back block's error flag reports the combined parity of both halves and the controller's parity bit, two cycles after the parity bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_n_i | input | 1 | Asynchronous active-low reset, released on the clock |
| mode_i | input | 1 | 0 = front or single block, 1 = back block of a chain |
| cs_a_n_i | input | 1 | First gating select, active low |
| cs_b_n_i | input | 1 | Second gating select, active low |
| data_i | input | DATA_W (24) | Command bus carrying both channel groups |
| par_i | input | NCH (2) | Late parity bit per channel |
| ppo_o | output | NCH (2) | Partial-parity result per channel |
| err_n_o | output | NCH (2) | Active-low error flag per channel, held two cycles |

## Verification
The assertions assume that mode_i is a strap: once reset is released it stays constant. They also assume that every input changes well away from the rising edge. The bench changes mode_i only while reset is held. It keeps the data bus at zero across each reset release, so that the parity delay line and the bench's own model begin from the same empty history. All inputs are driven on the falling edge. Gating selects, parity bits and data are drawn at random between the directed sequences.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

  typedef enum logic {
    PCC_FRONT = 1'b0,
    PCC_BACK  = 1'b1
  } pcc_mode_e;

  // Deepest parity lag supported, in cycles after the data
  localparam int unsigned PCC_LAG_MAX = 2;

endpackage

// File: rtl/pcc_rst_sync.sv
module pcc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/pcc_grp_align.sv
module pcc_grp_align
  import pcc_pkg::*;
#(
  parameter int unsigned          DATA_W  = 24,
  parameter logic [DATA_W-1:0]    MASK    = 24'h0007FF,
  parameter int unsigned          LAG_MAX = PCC_LAG_MAX
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  pcc_mode_e         mode_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              aligned_o
);

  localparam int unsigned TAP_FRONT = LAG_MAX - 2;
  localparam int unsigned TAP_BACK  = LAG_MAX - 1;
  localparam int unsigned AGE_W     = $clog2(LAG_MAX + 1);

  logic               grp_par;
  logic [LAG_MAX-1:0] dly_q;
  logic [LAG_MAX-1:0] dly_d;

  // Reduce the group to one bit before delaying: only LAG_MAX bits stored
  assign grp_par = ^(data_i & MASK);

  always_comb begin
    dly_d = {dly_q[LAG_MAX-2:0], grp_par};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dly_q <= '0;
    end else begin
      dly_q <= dly_d;
    end
  end

  assign aligned_o = (mode_i == PCC_BACK) ? dly_q[TAP_BACK] : dly_q[TAP_FRONT];

  // Cycles since reset release, saturating; arms the lag checks
  logic [AGE_W-1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      age_q <= '0;
    end else if (age_q != AGE_W'(LAG_MAX)) begin
      age_q <= age_q + 1'b1;
    end
  end

  AST_FRONT_LAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == PCC_FRONT && age_q >= AGE_W'(1)) |-> (aligned_o == $past(grp_par, 1)))
    else $error("front lag mismatch"); // R2

  AST_BACK_LAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == PCC_BACK && age_q >= AGE_W'(2)) |-> (aligned_o == $past(grp_par, 2)))
    else $error("back lag mismatch"); // R3

endmodule

// File: rtl/pcc_err_hold.sv
module pcc_err_hold #(
  parameter int unsigned HOLD_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic cmb_i,
  output logic ppo_o,
  output logic err_no
);

  localparam int unsigned CNT_W = (HOLD_CYC > 2) ? $clog2(HOLD_CYC) : 1;

  logic             ppo_q,   ppo_d;
  logic             err_n_q, err_n_d;
  logic [CNT_W-1:0] cnt_q,   cnt_d;

  always_comb begin
    ppo_d   = ppo_q;
    err_n_d = err_n_q;
    cnt_d   = cnt_q;
    if (en_i) begin
      ppo_d = cmb_i;
      if (cmb_i) begin
        cnt_d   = CNT_W'(HOLD_CYC - 1);
        err_n_d = 1'b0;
      end else if (cnt_q != '0) begin
        cnt_d   = cnt_q - 1'b1;
        err_n_d = 1'b0;
      end else begin
        err_n_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ppo_q   <= 1'b0;
      err_n_q <= 1'b1;
      cnt_q   <= '0;
    end else begin
      ppo_q   <= ppo_d;
      err_n_q <= err_n_d;
      cnt_q   <= cnt_d;
    end
  end

  assign ppo_o  = ppo_q;
  assign err_no = err_n_q;

  AST_GATE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(ppo_o) && $stable(err_no)))
    else $error("gated edge changed outputs"); // R6

  AST_ERR_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && cmb_i) |=> (!err_no && ppo_o))
    else $error("error not flagged"); // R4

  AST_PPO_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !cmb_i) |=> !ppo_o)
    else $error("clean parity gave ppo high"); // R2

  AST_ERR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(err_no) |=> !err_no)
    else $error("error flag released early"); // R5

endmodule

// File: rtl/par_cascade_chk.sv
module par_cascade_chk
  import pcc_pkg::*;
#(
  parameter int unsigned                  DATA_W   = 24,
  parameter int unsigned                  NCH      = 2,
  parameter logic [NCH-1:0][DATA_W-1:0]   GRP_MASK = {24'h7FF000, 24'h0007FF},
  parameter int unsigned                  HOLD_CYC = 2
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              mode_i,
  input  logic              cs_a_n_i,
  input  logic              cs_b_n_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [NCH-1:0]    par_i,
  output logic [NCH-1:0]    ppo_o,
  output logic [NCH-1:0]    err_n_o
);

  logic      rst_sync_n;
  logic      upd_en;
  pcc_mode_e mode_e;

  pcc_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i  (clk_i),
    .arst_ni(rst_n_i),
    .rst_no (rst_sync_n)
  );

  assign mode_e = pcc_mode_e'(mode_i);
  // Outputs update unless both selects are deasserted
  assign upd_en = !(cs_a_n_i && cs_b_n_i);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic aligned;
    logic cmb;

    pcc_grp_align #(
      .DATA_W (DATA_W),
      .MASK   (GRP_MASK[c]),
      .LAG_MAX(PCC_LAG_MAX)
    ) u_align (
      .clk_i    (clk_i),
      .rst_ni   (rst_sync_n),
      .mode_i   (mode_e),
      .data_i   (data_i),
      .aligned_o(aligned)
    );

    // Parity input enters the output register directly so a chained
    // back block sees the front result on its own lag
    assign cmb = aligned ^ par_i[c];

    pcc_err_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
      .clk_i (clk_i),
      .rst_ni(rst_sync_n),
      .en_i  (upd_en),
      .cmb_i (cmb),
      .ppo_o (ppo_o[c]),
      .err_no(err_n_o[c])
    );
  end

  AST_RST_OUT: assert property (@(posedge clk_i)
    !rst_n_i |=> ((ppo_o == '0) && (err_n_o == '1)))
    else $error("outputs not cleared in reset"); // R7

  AST_MODE_STRAP: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    rst_sync_n |=> $stable(mode_i))
    else $error("mode changed outside reset"); // R3

endmodule

// File: tb/par_cascade_chk_tb_top.sv
`timescale 1ns/1ps
module par_cascade_chk_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mode;
  logic        cs_a_n, cs_b_n;
  logic [23:0] data, fdata, bdata;
  logic [1:0]  par, fpar;
  logic [1:0]  ppo, err_n, f_ppo, f_err, b_ppo, b_err;

  always #2.5 clk = ~clk;

  par_cascade_chk dut_i (
    .clk_i(clk), .rst_n_i(rst_n), .mode_i(mode), .cs_a_n_i(cs_a_n), .cs_b_n_i(cs_b_n),
    .data_i(data), .par_i(par), .ppo_o(ppo), .err_n_o(err_n));

  par_cascade_chk front_i (
    .clk_i(clk), .rst_n_i(rst_n), .mode_i(1'b0), .cs_a_n_i(cs_a_n), .cs_b_n_i(cs_b_n),
    .data_i(fdata), .par_i(fpar), .ppo_o(f_ppo), .err_n_o(f_err));

  par_cascade_chk back_i (
    .clk_i(clk), .rst_n_i(rst_n), .mode_i(1'b1), .cs_a_n_i(cs_a_n), .cs_b_n_i(cs_b_n),
    .data_i(bdata), .par_i(f_ppo), .ppo_o(b_ppo), .err_n_o(b_err));

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Model state, device index 0 = dut_i, 1 = front_i, 2 = back_i
  logic [1:0] m_ppo [3];
  logic [1:0] m_err [3];
  int         m_cnt [3][2];
  logic [1:0] gp_d1 [3];
  logic [1:0] gp_d2 [3];

  logic [11:0] exp_q [$];
  string       tag_q [$];

  function automatic logic [1:0] gpar(input logic [23:0] d);
    return {^d[22:12], ^d[10:0]};
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 3; i++) begin
      m_ppo[i] = 2'b00; m_err[i] = 2'b11;
      gp_d1[i] = 2'b00; gp_d2[i] = 2'b00;
      m_cnt[i][0] = 0; m_cnt[i][1] = 0;
    end
  endtask

  task automatic step(input int dv, input int c, input logic cmb);
    m_ppo[dv][c] = cmb;
    if (cmb) begin
      m_err[dv][c] = 1'b0; m_cnt[dv][c] = 1;
    end else if (m_cnt[dv][c] > 0) begin
      m_err[dv][c] = 1'b0; m_cnt[dv][c]--;
    end else begin
      m_err[dv][c] = 1'b1;
    end
  endtask

  task automatic push_item(input string tag);
    exp_q.push_back({m_ppo[0], m_err[0], m_ppo[1], m_err[1], m_ppo[2], m_err[2]});
    tag_q.push_back(tag);
  endtask

  // Driver: one call per clock cycle, predicts the outputs after the next edge
  task automatic drive(input logic [23:0] d, input logic [1:0] p,
                       input logic ca, input logic cb, input string tag);
    logic [23:0] fd, bd;
    logic [1:0]  fp, al, bcmb;
    @(negedge clk);
    fd = 24'($urandom); bd = 24'($urandom); fp = 2'($urandom);
    data = d; par = p; cs_a_n = ca; cs_b_n = cb;
    fdata = fd; bdata = bd; fpar = fp;
    al   = mode ? gp_d2[0] : gp_d1[0];
    bcmb = gp_d2[2] ^ m_ppo[1];
    if (!(ca && cb)) begin
      for (int c = 0; c < 2; c++) begin
        step(0, c, al[c] ^ p[c]);
        step(1, c, gp_d1[1][c] ^ fp[c]);
        step(2, c, bcmb[c]);
      end
    end
    gp_d2[0] = gp_d1[0]; gp_d1[0] = gpar(d);
    gp_d2[1] = gp_d1[1]; gp_d1[1] = gpar(fd);
    gp_d2[2] = gp_d1[2]; gp_d1[2] = gpar(bd);
    push_item(tag);
  endtask

  task automatic chk_rst(input string tag);
    checks++;
    if ({ppo, err_n, f_ppo, f_err, b_ppo, b_err} !== 12'b00_11_00_11_00_11) begin
      fails++;
      $display("FAIL %s: reset outputs actual=%b expected=%b", tag,
               {ppo, err_n, f_ppo, f_err, b_ppo, b_err}, 12'b00_11_00_11_00_11);
    end
  endtask

  // Called just after a falling edge; R7: two edges after release stay in reset
  task automatic release_rst();
    rst_n = 1'b1; data = '0; fdata = '0; bdata = '0;
    cs_a_n = 1'b0; cs_b_n = 1'b0; par = 2'b11; fpar = 2'b11;
    push_item("R7");
    @(negedge clk);
    push_item("R7");
  endtask

  task automatic mid_reset(input logic new_mode);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk_rst("R7");
    model_reset();
    data = '0; fdata = '0; bdata = '0; par = '0; fpar = '0;
    cs_a_n = 1'b1; cs_b_n = 1'b1;
    @(negedge clk);
    mode = new_mode;
    repeat (3) @(negedge clk);
    release_rst();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  // Monitor: pops one expected item per clock edge
  logic [11:0] e;
  string       t;
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if ({ppo, err_n} !== e[11:8]) begin
        fails++;
        $display("FAIL %s: ppo/err_n actual=%b expected=%b", t, {ppo, err_n}, e[11:8]);
      end
      checks++;
      if ({f_ppo, f_err, b_ppo, b_err} !== e[7:0]) begin
        fails++;
        $display("FAIL R8: chain actual=%b expected=%b", {f_ppo, f_err, b_ppo, b_err}, e[7:0]);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; mode = 1'b0; cs_a_n = 1'b1; cs_b_n = 1'b1;
    data = '0; fdata = '0; bdata = '0; par = '0; fpar = '0;
    model_reset();
    repeat (3) @(negedge clk);
    #1;
    chk_rst("R7");
    @(negedge clk);
    release_rst();
    drive(24'h000000, 2'b11, 1'b0, 1'b0, "R7");

    // R2: even/odd groups against both parity values
    drive(24'h000001, 2'b00, 1'b0, 1'b0, "R2");
    drive(24'h001003, 2'b00, 1'b0, 1'b0, "R2");
    drive(24'h7FF7FF, 2'b01, 1'b0, 1'b0, "R2");
    drive(24'h000000, 2'b11, 1'b0, 1'b0, "R2");
    drive(24'h000000, 2'b00, 1'b0, 1'b0, "R4");
    drive(24'h000000, 2'b00, 1'b0, 1'b0, "R4");
    drive(24'h000000, 2'b00, 1'b0, 1'b0, "R4");
    // R1: excluded bits 11 and 23 toggle, no effect
    drive(24'h800800, 2'b00, 1'b0, 1'b0, "R1");
    drive(24'h000800, 2'b00, 1'b0, 1'b0, "R1");
    drive(24'h800000, 2'b00, 1'b0, 1'b0, "R1");
    drive(24'h001000, 2'b00, 1'b0, 1'b0, "R1");
    drive(24'h000000, 2'b10, 1'b0, 1'b0, "R1");
    // R5: single error then clean, then a restart during the hold
    drive(24'h000000, 2'b01, 1'b0, 1'b0, "R5");
    for (int i = 0; i < 4; i++) drive(24'h000000, 2'b00, 1'b0, 1'b0, "R5");
    drive(24'h000000, 2'b01, 1'b0, 1'b0, "R5");
    drive(24'h000000, 2'b00, 1'b0, 1'b0, "R5");
    drive(24'h000000, 2'b01, 1'b0, 1'b0, "R5");
    for (int i = 0; i < 4; i++) drive(24'h000000, 2'b00, 1'b0, 1'b0, "R5");
    // R6: both selects high freeze outputs; one low keeps it active
    drive(24'h000000, 2'b11, 1'b0, 1'b0, "R6");
    for (int i = 0; i < 3; i++) drive(24'h000003, 2'b00, 1'b1, 1'b1, "R6");
    drive(24'h000000, 2'b00, 1'b1, 1'b0, "R6");
    drive(24'h000000, 2'b10, 1'b0, 1'b1, "R6");
    drive(24'h000000, 2'b00, 1'b1, 1'b1, "R6");
    // Random front-mode traffic
    for (int i = 0; i < 200; i++) begin
      logic [1:0] cs = 2'($urandom);
      drive(24'($urandom), 2'($urandom), cs[0], cs[1], "R2");
    end
    // Error pending, then asynchronous reset and switch to back mode
    drive(24'h000000, 2'b11, 1'b0, 1'b0, "R4");
    mid_reset(1'b1);
    drive(24'h000000, 2'b11, 1'b0, 1'b0, "R7");
    // R3: parity two cycles after the data
    drive(24'h000001, 2'b00, 1'b0, 1'b0, "R3");
    drive(24'h000000, 2'b00, 1'b0, 1'b0, "R3");
    drive(24'h000000, 2'b01, 1'b0, 1'b0, "R3");
    drive(24'h001000, 2'b00, 1'b0, 1'b0, "R3");
    drive(24'h000000, 2'b00, 1'b0, 1'b0, "R3");
    drive(24'h000000, 2'b00, 1'b0, 1'b0, "R3");
    for (int i = 0; i < 200; i++) begin
      logic [1:0] cs = 2'($urandom);
      drive(24'($urandom), 2'($urandom), cs[0], cs[1], "R3");
    end
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule